// File: doc/BRIEF.md
# Interrupt to MSI Request Controller

This block sits between a handful of level-sensitive interrupt lines coming from user logic and the transaction layer of a PCIe endpoint. When any line goes high and the host has granted permission to send, it raises a single message request toward the transaction layer and keeps it raised until the acknowledge comes back. A new message is allowed only after the whole interrupt vector has been seen at zero. Interrupts that pile up while a line is still high are therefore folded into the message that was already sent, and host software must clear every source for each message it takes.

Permission to send comes from shadow copies of three configuration bits: the MSI enable flag, memory-space decoding and bus mastering. A fourth shadow bit, the interrupt-disable flag of the Command register, selects whether the older level-interrupt output may assert. A small read port returns the live interrupt vector at one fixed offset so that software can see which sources are pending.

Top module: `msi_irq_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) drops msi_req, clears rd_data to zero and leaves the block armed, so that the first interrupt after reset is sent.
- R2: While armed, with cfg_msi_enable (bit 16 of the dword at config offset 0x50), cfg_mem_space (Command bit 1) and cfg_bus_master (Command bit 2) all 1 and at least one irq_in bit at 1 at a clock edge, msi_req is 1 after that edge.
- R3: Once raised, msi_req stays 1 until a clock edge at which msi_ack is 1, and is 0 after that edge; the acknowledge may come at the first edge after the request rises or any number of cycles later.
- R4: After an acknowledged request, no further request is raised while any irq_in bit remains 1, even if the set of active bits changes.
- R5: The block re-arms at the first clock edge, following an acknowledge, at which irq_in is all zero; a later nonzero irq_in then raises a new request.
- R6: If any of the three enable bits is 0, no request is raised; when all three return to 1 while the block is armed and irq_in is still nonzero, the request is raised.
- R7: Clearing enable bits or irq_in while msi_req is 1 does not withdraw the request.
- R8: A read with rd_en at 1 and rd_addr equal to 0x40 returns, after the next clock edge, the value of irq_in at that edge zero-extended to 32 bits; a read of any other offset returns zero.
- R9: intx_irq is 1 exactly when some irq_in bit is 1, cfg_intx_disable (Command bit 10) is 0 and cfg_msi_enable is 0.
- R10: An msi_ack arriving while no request is raised has no effect: the block stays armed and the next interrupt is still sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_IRQ | Level-sensitive interrupt lines, 1 = requesting |
| cfg_msi_enable | input | 1 | Shadow of the MSI enable flag |
| cfg_mem_space | input | 1 | Shadow of Command memory-space enable |
| cfg_bus_master | input | 1 | Shadow of Command bus-master enable |
| cfg_intx_disable | input | 1 | Shadow of Command interrupt-disable flag |
| msi_ack | input | 1 | Acknowledge from the transaction layer |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register byte offset |
| msi_req | output | 1 | Message request to the transaction layer |
| intx_irq | output | 1 | Level interrupt output for the legacy path |
| rd_data | output | DATA_W | Read data, valid after the edge that took rd_en |

## Verification
The bench builds the block with NUM_IRQ of 4, DATA_W of 32, ADDR_W of 8 and the status offset at 0x40. Four lines are enough to change the set of active bits inside one interrupt episode, which is how the merging of back-to-back interrupts is exercised, and they leave 28 upper bits of the read word that must come back as zero. The eight-bit address lets the bench aim a read at a neighbouring offset and see it return nothing.

// File: rtl/msi_irq_pkg.sv
// Package msi_irq_pkg
// Shared type and helper functions for the interrupt to MSI request
// controller. Assumes the configuration shadows are single-bit copies
// kept current by the configuration space logic elsewhere.
package msi_irq_pkg;

    // Shadow copies of the configuration bits the block depends on.
    typedef struct packed {
        logic msi_on;     // MSI enable flag of the capability
        logic mem_on;     // Command: memory-space decoding
        logic master_on;  // Command: bus mastering
        logic intx_off;   // Command: interrupt-disable flag
    } cfg_shadow_t;

    // State of the request sequencer.
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_REQ   = 2'd1,
        ST_SPENT = 2'd2
    } arm_state_t;

    // A message may leave only with all three grants present.
    function automatic logic may_send(input cfg_shadow_t c);
        return c.msi_on & c.mem_on & c.master_on;
    endfunction

    // The level path is live only when neither MSI nor the disable flag is set.
    function automatic logic legacy_allowed(input cfg_shadow_t c);
        return ~c.intx_off & ~c.msi_on;
    endfunction

endpackage

// File: rtl/msi_cfg_gate.sv
// Module msi_cfg_gate
// Combines the configuration shadows into a send permission for the
// message path and drives the legacy level interrupt. Purely
// combinational; assumes the shadows are already in the clk domain.
module msi_cfg_gate
    import msi_irq_pkg::*;
(
    input  cfg_shadow_t cfg,
    input  logic        irq_any,
    output logic        send_ok,
    output logic        intx_out
);

    // Permission and legacy level from the shadow bits.
    always_comb begin
        send_ok  = may_send(cfg);
        intx_out = irq_any & legacy_allowed(cfg);
    end

endmodule

// File: rtl/msi_arm_seq.sv
// Module msi_arm_seq
// Three-state sequencer: armed, request outstanding, spent. Raises one
// request per interrupt episode and re-arms only when every line has
// been seen low. Assumes acknowledge is meaningful only while the
// request is raised; a stray acknowledge is ignored.
module msi_arm_seq
    import msi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_any,
    input  logic send_ok,
    input  logic ack,
    output logic req
);

    arm_state_t state_q;
    arm_state_t state_d;

    // Next-state choice for the episode tracker.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (send_ok && irq_any) state_d = ST_REQ;
            ST_REQ:   if (ack)                state_d = ST_SPENT;
            ST_SPENT: if (!irq_any)           state_d = ST_ARMED;
            default:                          state_d = ST_ARMED;
        endcase
    end

    // State register with synchronous active-low reset into the armed state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Request is a decode of the registered state.
    assign req = (state_q == ST_REQ);

endmodule

// File: rtl/msi_status_port.sv
// Module msi_status_port
// Read-only register port. One offset returns the live interrupt
// vector zero-extended to the data width; every other offset reads
// zero. Read data is registered and held between strobes.
module msi_status_port #(
    parameter int unsigned NUM_IRQ       = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned STATUS_OFFSET = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IRQ-1:0] irq_vec,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFFSET);

    logic [DATA_W-1:0] status_word;

    // Zero-extend the vector bit by bit into the status word.
    for (genvar b = 0; b < DATA_W; b++) begin : g_ext
        if (b < NUM_IRQ) begin : g_live
            assign status_word[b] = irq_vec[b];
        end else begin : g_pad
            assign status_word[b] = 1'b0;
        end
    end

    // Capture the addressed word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= (rd_addr == STATUS_ADDR) ? status_word : '0;
        end
    end

endmodule

// File: rtl/msi_irq_ctrl.sv
// Module msi_irq_ctrl
// Top of the interrupt to MSI request controller. Folds the interrupt
// vector into single message requests gated by the configuration
// shadows, drives the legacy level interrupt, and serves the status
// read. Assumes all inputs are synchronous to clk.
module msi_irq_ctrl
    import msi_irq_pkg::*;
#(
    parameter int unsigned NUM_IRQ       = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned STATUS_OFFSET = 'h40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               cfg_msi_enable,
    input  logic               cfg_mem_space,
    input  logic               cfg_bus_master,
    input  logic               cfg_intx_disable,
    input  logic               msi_ack,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               msi_req,
    output logic               intx_irq,
    output logic [DATA_W-1:0]  rd_data
);

    cfg_shadow_t cfg_view;
    logic        irq_any;
    logic        send_ok;

    // Gather the shadows and reduce the vector.
    always_comb begin
        cfg_view.msi_on    = cfg_msi_enable;
        cfg_view.mem_on    = cfg_mem_space;
        cfg_view.master_on = cfg_bus_master;
        cfg_view.intx_off  = cfg_intx_disable;
        irq_any            = |irq_in;
    end

    msi_cfg_gate u_gate (
        .cfg      (cfg_view),
        .irq_any  (irq_any),
        .send_ok  (send_ok),
        .intx_out (intx_irq)
    );

    msi_arm_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_any (irq_any),
        .send_ok (send_ok),
        .ack     (msi_ack),
        .req     (msi_req)
    );

    msi_status_port #(
        .NUM_IRQ       (NUM_IRQ),
        .DATA_W        (DATA_W),
        .ADDR_W        (ADDR_W),
        .STATUS_OFFSET (STATUS_OFFSET)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_vec (irq_in),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/msi_irq_ctrl_chk.sv
// Module msi_irq_ctrl_chk
// Protocol checker for msi_irq_ctrl, attached by bind. Keeps its own
// episode flag to tell whether the vector has been all zero since the
// last acknowledged request.
module msi_irq_ctrl_chk #(
    parameter int unsigned NUM_IRQ       = 4,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned STATUS_OFFSET = 'h40
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_in,
    input logic               cfg_msi_enable,
    input logic               cfg_mem_space,
    input logic               cfg_bus_master,
    input logic               cfg_intx_disable,
    input logic               msi_ack,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               msi_req,
    input logic               intx_irq,
    input logic [DATA_W-1:0]  rd_data
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_OFFSET);

    logic              gap_seen;
    logic [DATA_W-1:0] ext_vec;

    // Expected read word for the status offset.
    always_comb begin
        ext_vec = '0;
        ext_vec[NUM_IRQ-1:0] = irq_in;
    end

    // Tracks whether a zero vector has been seen since the last acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   gap_seen <= 1'b1;
        else if (msi_req && msi_ack)  gap_seen <= 1'b0;
        else if (irq_in == '0)        gap_seen <= 1'b1;
    end

    a_r1_reset_drops_req: assert property (@(posedge clk)
        !rst_n |=> !msi_req);

    a_r2_rise_needs_grants: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> $past(cfg_msi_enable && cfg_mem_space && cfg_bus_master));

    a_r2_rise_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> $past(irq_in != '0));

    a_r3_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && !msi_ack) |=> msi_req);

    a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_req && msi_ack) |=> !msi_req);

    a_r4_one_per_episode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> $past(gap_seen));

    a_r8_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == STATUS_ADDR) |=> rd_data == $past(ext_vec));

    a_r8_other_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != STATUS_ADDR) |=> rd_data == '0);

    a_r9_legacy_level: assert property (@(posedge clk) disable iff (!rst_n)
        intx_irq == ((irq_in != '0) && !cfg_intx_disable && !cfg_msi_enable));

endmodule

bind msi_irq_ctrl msi_irq_ctrl_chk #(
    .NUM_IRQ       (NUM_IRQ),
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .STATUS_OFFSET (STATUS_OFFSET)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .irq_in           (irq_in),
    .cfg_msi_enable   (cfg_msi_enable),
    .cfg_mem_space    (cfg_mem_space),
    .cfg_bus_master   (cfg_bus_master),
    .cfg_intx_disable (cfg_intx_disable),
    .msi_ack          (msi_ack),
    .rd_en            (rd_en),
    .rd_addr          (rd_addr),
    .msi_req          (msi_req),
    .intx_irq         (intx_irq),
    .rd_data          (rd_data)
);

// File: tb/msi_irq_ctrl_test.sv
`timescale 1ns/1ps
module msi_irq_ctrl_test;

    localparam int NI = 4;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int ROWS = 26;

    // Row layout: [10:7] irq, 6 msi, 5 mem, 4 master, 3 intx_dis, 2 ack,
    // 1 expected msi_req, 0 expected intx_irq
    localparam logic [10:0] TBL [0:ROWS-1] = '{
        11'b0000_1111_0_00, // 0  idle, R2
        11'b0001_1111_0_10, // 1  line 0 rises, R2
        11'b0001_1111_1_00, // 2  ack one cycle later, R3
        11'b0011_1111_0_00, // 3  more lines, merged R4
        11'b0010_1111_0_00, // 4  set changes, still merged R4
        11'b0000_1111_0_00, // 5  all low, re-arm R5
        11'b0100_1111_0_10, // 6  new episode R5
        11'b0100_1111_0_10, // 7  held R3
        11'b0000_1111_0_10, // 8  vector drops, still held R7
        11'b0000_1111_1_00, // 9  ack
        11'b0000_1111_0_00, // 10 re-arm
        11'b1000_0111_0_00, // 11 msi off R6
        11'b1000_1011_0_00, // 12 memory off R6
        11'b1000_1101_0_00, // 13 master off R6
        11'b1000_1111_0_10, // 14 grants return R6
        11'b1000_0001_0_10, // 15 grants drop while pending R7
        11'b1000_0001_1_00, // 16 ack
        11'b0000_1111_0_00, // 17 re-arm
        11'b0000_1111_1_00, // 18 stray ack R10
        11'b0001_1111_0_10, // 19 still armed R10
        11'b0001_1111_0_10, // 20 ack late R3
        11'b0001_1111_0_10, // 21
        11'b0001_1111_1_00, // 22 ack after three cycles
        11'b0001_0110_0_01, // 23 legacy path R9
        11'b0001_1110_0_00, // 24 msi on masks legacy R9
        11'b0000_0110_0_00  // 25 idle, re-arm
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NI-1:0] irq_in;
    logic          cfg_msi_enable, cfg_mem_space, cfg_bus_master, cfg_intx_disable;
    logic          msi_ack;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          msi_req;
    logic          intx_irq;
    logic [DW-1:0] rd_data;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    msi_irq_ctrl #(
        .NUM_IRQ (NI),
        .DATA_W  (DW),
        .ADDR_W  (AW),
        .STATUS_OFFSET ('h40)
    ) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .irq_in           (irq_in),
        .cfg_msi_enable   (cfg_msi_enable),
        .cfg_mem_space    (cfg_mem_space),
        .cfg_bus_master   (cfg_bus_master),
        .cfg_intx_disable (cfg_intx_disable),
        .msi_ack          (msi_ack),
        .rd_en            (rd_en),
        .rd_addr          (rd_addr),
        .msi_req          (msi_req),
        .intx_irq         (intx_irq),
        .rd_data          (rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        if (i <= 2)       return "R2 R3";
        else if (i <= 5)  return "R4 R5";
        else if (i <= 10) return "R3 R7";
        else if (i <= 16) return "R6 R7";
        else if (i <= 22) return "R10 R3";
        else              return "R9";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        irq_in = '0;
        cfg_msi_enable = 1'b0;
        cfg_mem_space = 1'b0;
        cfg_bus_master = 1'b0;
        cfg_intx_disable = 1'b1;
        msi_ack = 1'b0;
        rd_en = 1'b0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 req after reset", 32'(msi_req), 32'd0);
        check("R1 rd_data after reset", rd_data, 32'd0);
        rst_n = 1'b1;

        // Table walk: apply a row, one edge, compare
        for (int i = 0; i < ROWS; i++) begin
            irq_in           = TBL[i][10:7];
            cfg_msi_enable   = TBL[i][6];
            cfg_mem_space    = TBL[i][5];
            cfg_bus_master   = TBL[i][4];
            cfg_intx_disable = TBL[i][3];
            msi_ack          = TBL[i][2];
            @(negedge clk);
            check($sformatf("%s row %0d msi_req", row_tag(i), i), 32'(msi_req), 32'(TBL[i][1]));
            check($sformatf("R9 row %0d intx_irq", i), 32'(intx_irq), 32'(TBL[i][0]));
        end
        msi_ack = 1'b0;

        // R8: status reads with grants off so no request forms
        cfg_msi_enable = 1'b0;
        irq_in = 4'b1010;
        rd_en = 1'b1;
        rd_addr = 8'h40;
        @(negedge clk);
        check("R8 status 0x40", rd_data, 32'h0000_000A);
        rd_addr = 8'h44;
        @(negedge clk);
        check("R8 other offset", rd_data, 32'd0);
        irq_in = 4'b1111;
        rd_addr = 8'h40;
        @(negedge clk);
        check("R8 status all lines", rd_data, 32'h0000_000F);
        rd_en = 1'b0;

        // R6: block stayed armed while grants were off; grant now
        cfg_msi_enable = 1'b1;
        @(negedge clk);
        check("R6 request after grant", 32'(msi_req), 32'd1);

        // R1: reset while a request is outstanding
        rst_n = 1'b0;
        irq_in = '0;
        @(negedge clk);
        check("R1 reset drops req", 32'(msi_req), 32'd0);
        check("R1 reset clears rd_data", rd_data, 32'd0);
        rst_n = 1'b1;
        // R1: armed out of reset, first interrupt goes out
        irq_in = 4'b0100;
        @(negedge clk);
        check("R1 armed after reset", 32'(msi_req), 32'd1);
        msi_ack = 1'b1;
        @(negedge clk);
        check("R3 drop after ack", 32'(msi_req), 32'd0);
        msi_ack = 1'b0;
        irq_in = 4'b0110;
        @(negedge clk);
        check("R4 no second request", 32'(msi_req), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule